// File: doc/BRIEF.md
# Configurable UART Character Transmitter

This block turns one byte into an asynchronous serial frame whose shape is chosen at run time by an 8-bit framing control word. The word selects 5 to 8 data bits, an optional parity bit (odd, even, or a fixed "stick" value), and one, one-and-a-half or two stop bits. A further control bit forces the line to the spacing level to signal a break.

Timing comes from a 16x baud enable tick supplied by an external divisor. A single-cycle write strobe with a data byte starts a frame when the block is idle. A busy flag tells the host when the next character can be written. The control word is sampled when a frame starts and holds for the whole frame. The break bit is the exception: it acts on the line at once.

Top module: `uart_char_tx`

## Requirements
- R1: After reset, and while idle with break clear, `txd_o` is high and `busy_o` is low. A write (`wr_i` high while `busy_o` is low) makes `busy_o` high and `txd_o` low on the next clock. This start bit lasts 16 ticks.
- R2: `lcr_i[1:0]` sets the number of data bits: 0→5, 1→6, 2→7, 3→8. Data bits follow the start bit LSB first, and each lasts 16 ticks.
- R3: When `lcr_i[3]`=1, one 16-tick parity bit follows the last data bit. When `lcr_i[3]`=0, the first stop bit follows the last data bit directly.
- R4: With parity on and stick off, `lcr_i[4]`=1 gives a parity bit equal to the XOR of the sent data bits (even parity). `lcr_i[4]`=0 gives its inverse (odd parity).
- R5: With parity on and `lcr_i[5]`=1, the parity bit is constant: 0 if `lcr_i[4]`=1, and 1 if `lcr_i[4]`=0.
- R6: The stop period is high. It lasts 16 ticks when `lcr_i[2]`=0, 24 ticks when `lcr_i[2]`=1 with 5 data bits, and 32 ticks when `lcr_i[2]`=1 with 6, 7 or 8 data bits.
- R7: When `lcr_i[6]`=1, `txd_o` is low from the next clock on, whether a frame is running or not. The frame timing and `busy_o` carry on unchanged. Clearing the bit restores the scheduled line level on the next clock.
- R8: `lcr_i[7]` has no effect on the transmitted frame.
- R9: `lcr_i` bits other than bit 6 are captured when the frame starts. Changing them during the frame does not alter it.
- R10: A write while `busy_o` is high is ignored. The running frame is unchanged, and no second frame follows it.
- R11: `busy_o` falls on the clock of the final stop tick, so the frame lasts exactly its total tick count. Without a tick, `busy_o` and the line do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Enable pulse at 16x the baud rate |
| wr_i | input | 1 | Write strobe for the transmit byte |
| wdata_i | input | 8 | Byte to transmit |
| lcr_i | input | 8 | Framing control word |
| txd_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | High while a frame is running |

## Verification
The bench predicts the line level for every tick of every frame and compares it against the design. A design that miscounts word length, places parity in the wrong slot or computes it with the wrong sense, or gets the 24-tick half-stop case wrong shows up as a line mismatch or a busy flag that ends at the wrong tick. Further cases rewrite the control word during a frame, write during a frame, and pulse break during a frame and while idle. A design that reads the control word live, starts a second frame, or lets break disturb the bit timing then sends bits that differ from the prediction.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = 3;
endpackage

// File: rtl/uart_tx_cfg_decode.sv
module uart_tx_cfg_decode
  import uart_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned CNT_W         = $clog2(2 * TICKS_PER_BIT)
) (
  input  logic [7:0]        lcr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [IDX_W-1:0]  last_idx_o,
  output logic              par_en_o,
  output logic              par_val_o,
  output logic [CNT_W-1:0]  stop_last_o
);
  localparam int unsigned HALF = TICKS_PER_BIT / 2;
  localparam logic [CNT_W-1:0] STOP_ONE  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] STOP_HALF = CNT_W'(TICKS_PER_BIT + HALF - 1);
  localparam logic [CNT_W-1:0] STOP_TWO  = CNT_W'(2 * TICKS_PER_BIT - 1);

  logic [DATA_W-1:0] mask;
  logic              data_xor;
  logic              unused_dlab;

  assign unused_dlab = lcr_i[7];
  assign last_idx_o  = IDX_W'(3'd4 + {1'b0, lcr_i[1:0]});
  assign mask        = 8'hFF >> (2'd3 - lcr_i[1:0]);
  assign data_xor    = ^(data_i & mask);
  assign par_en_o    = lcr_i[3];

  always_comb begin
    if (lcr_i[5])      par_val_o = ~lcr_i[4];
    else if (lcr_i[4]) par_val_o = data_xor;
    else               par_val_o = ~data_xor;
  end

  always_comb begin
    if (!lcr_i[2])               stop_last_o = STOP_ONE;
    else if (lcr_i[1:0] == 2'b0) stop_last_o = STOP_HALF;
    else                         stop_last_o = STOP_TWO;
  end
endmodule

// File: rtl/uart_tx_tick_cnt.sv
module uart_tx_tick_cnt #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = tick_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned CNT_W         = $clog2(2 * TICKS_PER_BIT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wrap_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  last_idx_i,
  input  logic              par_en_i,
  input  logic              par_val_i,
  input  logic [CNT_W-1:0]  stop_last_i,
  output logic              cnt_clr_o,
  output logic [CNT_W-1:0]  phase_last_o,
  output logic              line_o,
  output logic              busy_o
);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(TICKS_PER_BIT - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_idx_q;
  logic              par_en_q;
  logic              par_val_q;
  logic [CNT_W-1:0]  stop_last_q;
  logic              line_q;

  assign busy_o       = (state_q != ST_IDLE);
  assign cnt_clr_o    = (state_q == ST_IDLE);
  assign phase_last_o = (state_q == ST_STOP) ? stop_last_q : BIT_LAST;
  assign line_o       = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sh_q        <= '0;
      idx_q       <= '0;
      last_idx_q  <= '0;
      par_en_q    <= 1'b0;
      par_val_q   <= 1'b0;
      stop_last_q <= '0;
      line_q      <= 1'b1;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_q     <= ST_START;
        sh_q        <= data_i;
        idx_q       <= '0;
        last_idx_q  <= last_idx_i;
        par_en_q    <= par_en_i;
        par_val_q   <= par_val_i;
        stop_last_q <= stop_last_i;
        line_q      <= 1'b0;
      end
    end else if (wrap_i) begin
      unique case (state_q)
        ST_START: begin
          state_q <= ST_DATA;
          line_q  <= sh_q[0];
        end
        ST_DATA: begin
          if (idx_q == last_idx_q) begin
            state_q <= par_en_q ? ST_PARITY : ST_STOP;
            line_q  <= par_en_q ? par_val_q : 1'b1;
          end else begin
            idx_q  <= idx_q + 1'b1;
            sh_q   <= sh_q >> 1;
            line_q <= sh_q[1];
          end
        end
        ST_PARITY: begin
          state_q <= ST_STOP;
          line_q  <= 1'b1;
        end
        default: begin
          state_q <= ST_IDLE;
          line_q  <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_char_tx.sv
module uart_char_tx
  import uart_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick16_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] lcr_i,
  output logic       txd_o,
  output logic       busy_o
);
  localparam int unsigned CNT_W = $clog2(2 * TICKS_PER_BIT);

  logic [IDX_W-1:0] last_idx;
  logic             par_en;
  logic             par_val;
  logic [CNT_W-1:0] stop_last;
  logic [CNT_W-1:0] phase_last;
  logic             cnt_clr;
  logic             wrap;
  logic             line;
  logic             busy;
  logic             brk_q;

  uart_tx_cfg_decode #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .CNT_W        (CNT_W)
  ) u_dec (
    .lcr_i      (lcr_i),
    .data_i     (wdata_i),
    .last_idx_o (last_idx),
    .par_en_o   (par_en),
    .par_val_o  (par_val),
    .stop_last_o(stop_last)
  );

  uart_tx_tick_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .tick_i(tick16_i),
    .last_i(phase_last),
    .wrap_o(wrap)
  );

  uart_tx_seq #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .CNT_W        (CNT_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (wr_i && !busy),
    .wrap_i      (wrap),
    .data_i      (wdata_i),
    .last_idx_i  (last_idx),
    .par_en_i    (par_en),
    .par_val_i   (par_val),
    .stop_last_i (stop_last),
    .cnt_clr_o   (cnt_clr),
    .phase_last_o(phase_last),
    .line_o      (line),
    .busy_o      (busy)
  );

  // break acts live, not captured per frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brk_q <= 1'b0;
    else         brk_q <= lcr_i[6];
  end

  assign txd_o  = line & ~brk_q;
  assign busy_o = busy;
endmodule

// File: rtl/uart_char_tx_chk.sv
module uart_char_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick16_i,
  input logic       wr_i,
  input logic [7:0] lcr_i,
  input logic       txd_o,
  input logic       busy_o
);
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !wr_i && !lcr_i[6]) |=> (txd_o && !busy_o)); // R1

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o && !lcr_i[6]) |=> (busy_o && !txd_o)); // R1

  AST_BREAK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcr_i[6] |=> !txd_o); // R7

  AST_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_i && !tick16_i) |=> busy_o); // R10

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick16_i) |=> $stable(busy_o)); // R11
endmodule

bind uart_char_tx uart_char_tx_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick16_i(tick16_i),
  .wr_i    (wr_i),
  .lcr_i   (lcr_i),
  .txd_o   (txd_o),
  .busy_o  (busy_o)
);

// File: tb/sim_uart_char_tx.sv
module sim_uart_char_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] lcr = 8'h00;
  logic       txd;
  logic       busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_char_tx u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick16_i(tick),
    .wr_i    (wr),
    .wdata_i (wdata),
    .lcr_i   (lcr),
    .txd_o   (txd),
    .busy_o  (busy)
  );

  function automatic int nbits(input logic [7:0] c);
    return 5 + int'(c[1:0]);
  endfunction

  function automatic int stop_len(input logic [7:0] c);
    if (!c[2]) return 16;
    return (c[1:0] == 2'b00) ? 24 : 32;
  endfunction

  function automatic int frame_len(input logic [7:0] c);
    return 16 * (1 + nbits(c) + int'(c[3])) + stop_len(c);
  endfunction

  function automatic logic par_bit(input logic [7:0] c, input logic [7:0] d);
    logic x = 1'b0;
    for (int i = 0; i < nbits(c); i++) x ^= d[i];
    if (c[5]) return ~c[4];
    return c[4] ? x : ~x;
  endfunction

  function automatic logic exp_level(input logic [7:0] c, input logic [7:0] d, input int j);
    int slot = j / 16;
    int n = nbits(c);
    if (slot == 0) return 1'b0;
    if (slot <= n) return d[slot-1];
    if (c[3] && slot == n + 1) return par_bit(c, d);
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  // mode: 0 plain, 1 rewrite lcr mid-frame, 2 write mid-frame, 3 break mid-frame
  task automatic send(input logic [7:0] c, input logic [7:0] d, input int mode, input string req);
    int t = frame_len(c);
    logic brk_exp = 1'b0;
    @(negedge clk);
    lcr = c;
    wdata = d;
    wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
    check("R1", busy, 1'b1);
    for (int j = 0; j < t; j++) begin
      check(req, txd, brk_exp ? 1'b0 : exp_level(c, d, j));
      if (j == t - 1) check("R11", busy, 1'b1);
      if (mode == 1 && j == 20) begin
        lcr = 8'($urandom) & 8'hBF;
        wdata = 8'($urandom);
      end
      if (mode == 2 && j == t / 2) begin
        wdata = ~d;
        wr = 1'b1;
      end
      if (mode == 3 && j == t / 3) begin
        lcr[6] = 1'b1;
        brk_exp = 1'b1;
      end
      if (mode == 3 && j == t / 2) begin
        lcr[6] = 1'b0;
        brk_exp = 1'b0;
      end
      pulse_tick();
      wr = 1'b0;
    end
    check("R11", busy, 1'b0);
    check("R6", txd, 1'b1);
    if (mode == 2) begin
      repeat (3) pulse_tick();
      check("R10", busy, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", txd, 1'b1);
    check("R1", busy, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", txd, 1'b1);
    check("R1", busy, 1'b0);

    // directed corners
    send(8'h00, 8'hA5, 0, "R2");
    send(8'h03, 8'h3C, 0, "R2");
    send(8'h0B, 8'h71, 0, "R3");
    send(8'h1A, 8'h5B, 0, "R4");
    send(8'h09, 8'h5B, 0, "R4");
    send(8'h28, 8'h00, 0, "R5");
    send(8'h3B, 8'hFF, 0, "R5");
    send(8'h04, 8'h15, 0, "R6");
    send(8'h05, 8'h2A, 0, "R6");
    send(8'h0F, 8'hC3, 0, "R6");
    send(8'h8B, 8'h71, 0, "R8");
    send(8'h1C, 8'h96, 1, "R9");
    send(8'h03, 8'h81, 2, "R10");
    send(8'h0E, 8'h6D, 3, "R7");

    // break while idle
    @(negedge clk);
    lcr = 8'h40;
    @(posedge clk);
    @(negedge clk);
    check("R7", txd, 1'b0);
    check("R7", busy, 1'b0);
    lcr = 8'h00;
    @(posedge clk);
    @(negedge clk);
    check("R7", txd, 1'b1);

    // random frames
    for (int k = 0; k < 40; k++) begin
      send(8'($urandom) & 8'hBF, 8'($urandom), int'($urandom_range(0, 3)), "R2");
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule